// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Sample Voting

This block receives asynchronous serial frames (one start bit, 5 to 9 data bits sent least significant bit first, an optional parity bit, one stop bit) on a single line. It does not make its own bit timing: a baud tick enable, produced outside the block, arrives either 16 or 8 times per bit period, chosen by a double-speed input. The line first passes through a two-flop synchronizer. A state machine then tracks each bit with a sample counter that moves only on a tick, and settles every bit by a majority vote of three samples taken around the bit's centre.

Finished words, each carrying a frame error flag and a parity error flag, enter a two-word receive queue. The head of the queue is shown on the read port while the valid flag is high, and a read strobe removes it. Clearing the enable empties the queue and parks the state machine. A frame that completes while the queue is full is discarded and raises an overrun flag.

The state machine has five states. IDLE waits for a low sample. START checks the start bit and returns to IDLE if the vote is high (a glitch). Otherwise it moves to DATA at the end of the bit. DATA collects the configured number of bits and then moves to PARITY when parity is enabled, or to STOP when it is not. PARITY moves to STOP after one bit. STOP returns to IDLE right after its last voting sample. Any state goes to IDLE when the enable is low.

Top module: `vote_uart_rx`

## Requirements
- R1: After reset, `rd_valid` and `overrun` are 0.
- R2: With `dbl_speed`=0 a bit spans 16 ticks and with `dbl_speed`=1 it spans 8. The sample counter does not move on a clock without `baud_tick`, so a low level on `rx_in` that no tick samples starts no frame.
- R3: Sample 1 of a bit is the first tick of that bit. The bit value is the majority of samples 8, 9 and 10 (normal) or 4, 5 and 6 (double speed). One inverted sample among the three leaves the bit unchanged, and two inverted samples flip it.
- R4: A low sample in IDLE starts a start-bit check. If the start bit's vote is 1, no word is produced and the receiver waits for the next low sample.
- R5: `word_len` selects the number of data bits, received least significant bit first and right-aligned in `rd_data`, with the unused upper bits 0. A value below 5 acts as 5 and a value above 9 acts as 9.
- R6: `parity_sel` encoding: 2'b0x means no parity bit, 2'b10 means even, 2'b11 means odd. If the received parity bit does not give the selected parity over the data bits, `rd_parity_err` is 1 for that word.
- R7: A stop bit that votes 0 still stores the word, with `rd_frame_err` set to 1.
- R8: A start bit whose first sample comes on the tick right after the stop bit's last voting sample (sample 10 normal, sample 6 double speed) is received.
- R9: The queue holds two words in arrival order. `rd_valid` is 1 when a word is present, and `rd_en` while `rd_valid` is 1 removes the head.
- R10: A frame that completes with two words queued is dropped and sets `overrun`. A read or a disable clears `overrun`.
- R11: While `rx_en` is 0 the queue is empty one clock later and stays empty, and frames on `rx_in` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low flushes the queue |
| baud_tick | input | 1 | Sample enable, 16 or 8 per bit |
| dbl_speed | input | 1 | 1 selects 8 samples per bit |
| word_len | input | 4 | Number of data bits (5 to 9) |
| parity_sel | input | 2 | Parity mode |
| rx_in | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Removes the head word |
| rd_valid | output | 1 | A word is waiting |
| rd_data | output | 9 | Head word data |
| rd_frame_err | output | 1 | Head word stop bit voted 0 |
| rd_parity_err | output | 1 | Head word parity mismatch |
| overrun | output | 1 | A word was lost to a full queue |

## Verification
Random frames with a fixed seed mix word length, parity mode, speed mode, data, and sometimes a bad parity or stop bit. Comparing their output with bench-computed words shows whether bit order, length clamping and the error flags work in both speeds. Directed patterns corrupt one or two centre samples, which tells a three-sample vote apart from a single-point sample. Low pulses that are too short, or that no tick samples, separate glitch rejection from false starts. A start bit right after the shortened stop tests early restart. Three frames with no reads, and a disable with words queued, test overrun and flush.

// File: rtl/vote_uart_rx_pkg.sv
package vote_uart_rx_pkg;

    localparam int WORD_W    = 9;   // widest data word
    localparam int MIN_LEN   = 5;   // narrowest data word
    localparam int LEN_W     = 4;   // width of the length selector
    localparam int SPB_NORM  = 16;  // samples per bit, normal
    localparam int SPB_DBL   = 8;   // samples per bit, double speed
    localparam int VOTE_NORM = 8;   // first voting sample, normal
    localparam int VOTE_DBL  = 4;   // first voting sample, double speed
    localparam int CNT_W     = $clog2(SPB_NORM + 1);
    localparam int IDX_W     = $clog2(WORD_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              frame_err;
        logic              parity_err;
    } rx_word_t;

endpackage

// File: rtl/vote_uart_rx_sync.sv
module vote_uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/vote_uart_rx_fsm.sv
module vote_uart_rx_fsm
    import vote_uart_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             dbl,
    input  logic             rxd,
    input  logic [LEN_W-1:0] word_len,
    input  logic [1:0]       parity_sel,
    output logic             push,
    output rx_word_t         word,
    output rx_state_t        state,
    output logic [CNT_W-1:0] cnt
);

    rx_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_nx, last_smp, first_vote, final_vote;
    logic [1:0]       early_q;
    logic [IDX_W-1:0] idx_q, idx_last;
    logic [WORD_W-1:0] bits_q;
    logic             par_q;
    logic             vote, at_wrap, at_final, par_on, par_odd;

    // sample numbering depends on the speed mode
    assign last_smp   = dbl ? CNT_W'(SPB_DBL)  : CNT_W'(SPB_NORM);
    assign first_vote = dbl ? CNT_W'(VOTE_DBL) : CNT_W'(VOTE_NORM);
    assign final_vote = first_vote + CNT_W'(2);
    assign cnt_nx     = (cnt_q >= last_smp) ? CNT_W'(1) : cnt_q + CNT_W'(1);
    assign at_wrap    = tick && (cnt_q >= last_smp);
    assign at_final   = tick && (cnt_nx == final_vote);
    assign vote       = (early_q[0] & early_q[1]) | (early_q[0] & rxd) | (early_q[1] & rxd);
    assign par_on     = parity_sel[1];
    assign par_odd    = parity_sel[0];

    always_comb begin
        if (word_len < LEN_W'(MIN_LEN))
            idx_last = IDX_W'(MIN_LEN - 1);
        else if (word_len > LEN_W'(WORD_W))
            idx_last = IDX_W'(WORD_W - 1);
        else
            idx_last = IDX_W'(word_len) - IDX_W'(1);
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (tick && !rxd) st_d = ST_START;
            ST_START: begin
                if (at_final && vote)  st_d = ST_IDLE;
                else if (at_wrap)      st_d = ST_DATA;
            end
            ST_DATA:   if (at_wrap && idx_q == idx_last)
                           st_d = par_on ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_wrap) st_d = ST_STOP;
            ST_STOP:   if (at_final) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
        if (!en) st_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // counter, vote storage and word assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            early_q <= '0;
            idx_q   <= '0;
            bits_q  <= '0;
            par_q   <= 1'b0;
            push    <= 1'b0;
            word    <= '0;
        end else begin
            push <= 1'b0;
            if (!en) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else if (tick) begin
                if (st_q == ST_IDLE) begin
                    cnt_q  <= rxd ? CNT_W'(0) : CNT_W'(1);
                    idx_q  <= '0;
                    bits_q <= '0;
                end else begin
                    cnt_q <= cnt_nx;
                    if (cnt_nx == first_vote)              early_q[0] <= rxd;
                    if (cnt_nx == first_vote + CNT_W'(1))  early_q[1] <= rxd;
                    if (at_final) begin
                        unique case (st_q)
                            ST_DATA:   bits_q[idx_q] <= vote;
                            ST_PARITY: par_q <= vote;
                            ST_STOP: begin
                                push            <= 1'b1;
                                word.data       <= bits_q;
                                word.frame_err  <= ~vote;
                                word.parity_err <= par_on & (^bits_q ^ par_q ^ par_odd);
                            end
                            default: ;
                        endcase
                    end
                    if (at_wrap && st_q == ST_DATA) idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    assign state = st_q;
    assign cnt   = cnt_q;

endmodule

// File: rtl/vote_uart_rx_fifo.sv
module vote_uart_rx_fifo
    import vote_uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     push,
    input  rx_word_t din,
    input  logic     pop,
    output rx_word_t dout,
    output logic     empty,
    output logic     ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    rx_word_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [LW-1:0]   level;
    logic            full, do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      level <= level + LW'(1);
            else if (do_pop && !do_push) level <= level - LW'(1);
            if (push && full)  ovf <= 1'b1;
            else if (do_pop)   ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/vote_uart_rx.sv
module vote_uart_rx
    import vote_uart_rx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              baud_tick,
    input  logic              dbl_speed,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [1:0]        parity_sel,
    input  logic              rx_in,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_frame_err,
    output logic              rd_parity_err,
    output logic              overrun
);

    logic             rx_sync;
    logic             rec_push, rec_busy, q_empty;
    rx_word_t         rec_word, head;
    rx_state_t        rec_state;
    logic [CNT_W-1:0] rec_cnt;

    vote_uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_sync)
    );

    vote_uart_rx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rx_en),
        .tick       (baud_tick),
        .dbl        (dbl_speed),
        .rxd        (rx_sync),
        .word_len   (word_len),
        .parity_sel (parity_sel),
        .push       (rec_push),
        .word       (rec_word),
        .state      (rec_state),
        .cnt        (rec_cnt)
    );

    vote_uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!rx_en),
        .push  (rec_push),
        .din   (rec_word),
        .pop   (rd_en),
        .dout  (head),
        .empty (q_empty),
        .ovf   (overrun)
    );

    assign rec_busy      = (rec_state != ST_IDLE);
    assign rd_valid      = !q_empty;
    assign rd_data       = head.data;
    assign rd_frame_err  = head.frame_err;
    assign rd_parity_err = head.parity_err;

endmodule

// File: rtl/vote_uart_rx_chk.sv
module vote_uart_rx_chk
    import vote_uart_rx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             baud_tick,
    input logic             rd_valid,
    input logic             overrun,
    input logic             rec_push,
    input logic             rec_busy,
    input logic [CNT_W-1:0] rec_cnt
);

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !baud_tick) |=> $stable(rec_cnt));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_busy |-> (rec_cnt >= CNT_W'(1) && rec_cnt <= CNT_W'(SPB_NORM)));

    p_push_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_push && rx_en) |=> rd_valid);

    p_overrun_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rd_valid));

    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rd_valid && !overrun && !rec_busy));

endmodule

bind vote_uart_rx vote_uart_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .baud_tick (baud_tick),
    .rd_valid  (rd_valid),
    .overrun   (overrun),
    .rec_push  (rec_push),
    .rec_busy  (rec_busy),
    .rec_cnt   (rec_cnt)
);

// File: tb/vote_uart_rx_tb_top.sv
module vote_uart_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       tick_gate = 1'b1;
    logic       dbl_speed = 1'b0;
    logic [3:0] word_len = 4'd8;
    logic [1:0] parity_sel = 2'b00;
    logic       rx_in = 1'b1;
    logic       rd_en = 1'b0;
    logic       rd_valid, rd_frame_err, rd_parity_err, overrun;
    logic [8:0] rd_data;
    logic [1:0] tdiv;
    logic       baud_tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) tdiv <= 2'd0;
        else        tdiv <= tdiv + 2'd1;
    end
    assign baud_tick = tick_gate && (tdiv == 2'd0);

    vote_uart_rx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_en         (rx_en),
        .baud_tick     (baud_tick),
        .dbl_speed     (dbl_speed),
        .word_len      (word_len),
        .parity_sel    (parity_sel),
        .rx_in         (rx_in),
        .rd_en         (rd_en),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_frame_err  (rd_frame_err),
        .rd_parity_err (rd_parity_err),
        .overrun       (overrun)
    );

    function automatic int eff_len(input int w);
        if (w < 5) return 5;
        if (w > 9) return 9;
        return w;
    endfunction

    function automatic logic [8:0] mask_w(input logic [8:0] d, input int nb);
        return d & ((9'h1 << nb) - 9'h1);
    endfunction

    function automatic logic par_of(input logic [8:0] d, input int nb, input logic odd);
        return (^mask_w(d, nb)) ^ odd;
    endfunction

    function automatic int spb();
        return dbl_speed ? 8 : 16;
    endfunction

    function automatic int first_vote();
        return dbl_speed ? 4 : 8;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic slot(input logic v);
        forever begin
            @(negedge clk);
            if (baud_tick) break;
        end
        rx_in = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) slot(1'b1);
    endtask

    task automatic send_bit(input logic v, input int f1, input int f2);
        for (int j = 1; j <= spb(); j++)
            slot((j == f1 || j == f2) ? ~v : v);
    endtask

    // nflip: 0 none, 1 one centre sample, 2 two centre samples on data bit fidx
    task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                              input bit short_stop, input int fidx, input int nflip);
        int nb = eff_len(int'(word_len));
        int fv = first_vote();
        send_bit(1'b0, 0, 0);
        for (int b = 0; b < nb; b++) begin
            if (b == fidx && nflip == 1)      send_bit(d[b], fv + 1, 0);
            else if (b == fidx && nflip == 2) send_bit(d[b], fv, fv + 1);
            else                              send_bit(d[b], 0, 0);
        end
        if (parity_sel[1]) send_bit(par_of(d, nb, parity_sel[0]) ^ bad_par, 0, 0);
        if (short_stop) for (int j = 0; j < fv + 2; j++) slot(~bad_stop);
        else            send_bit(~bad_stop, 0, 0);
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rd_valid) break;
        end
    endtask

    task automatic expect_head(input logic [8:0] d, input logic fe, input logic pe,
                               input string req);
        chk(rd_valid == 1'b1, req, "valid", rd_valid, 1);
        chk(rd_data == d, req, "data", rd_data, d);
        chk(rd_frame_err == fe, "R7", "frame_err", rd_frame_err, fe);
        chk(rd_parity_err == pe, "R6", "parity_err", rd_parity_err, pe);
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic frame_and_check(input logic [8:0] d, input bit bp, input bit bs,
                                   input string req);
        int nb = eff_len(int'(word_len));
        send_frame(d, bp, bs, 1'b0, -1, 0);
        idle(spb());
        wait_valid();
        expect_head(mask_w(d, nb), bs, parity_sel[1] & bp, req);
        pop();
        chk(rd_valid == 1'b0, "R9", "empty after read", rd_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        logic [8:0] d, a, b2, c;
        logic [1:0] pm;
        seed_sink = $urandom(32'h1F2E3D);

        repeat (5) @(negedge clk);
        chk(rd_valid == 1'b0, "R1", "valid after reset", rd_valid, 0);
        chk(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0 && overrun == 1'b0, "R1", "outputs out of reset",
            {rd_valid, overrun}, 0);
        rx_en = 1'b1;
        idle(20);

        // random frames in both speeds, all lengths and parity modes
        for (int i = 0; i < 16; i++) begin
            bit bp, bs;
            case ($urandom % 3)
                0: pm = 2'b00;
                1: pm = 2'b10;
                default: pm = 2'b11;
            endcase
            parity_sel = pm;
            word_len   = 4'(5 + $urandom % 5);
            dbl_speed  = 1'($urandom % 2);
            d  = 9'($urandom);
            bp = ($urandom % 4) == 0;
            bs = ($urandom % 5) == 0;
            idle(4);
            frame_and_check(d, bp, bs, dbl_speed ? "R2" : "R5");
        end

        // R3: voting against corrupted centre samples, both speeds
        parity_sel = 2'b00;
        word_len = 4'd8;
        for (int m = 0; m < 2; m++) begin
            dbl_speed = 1'(m);
            idle(4);
            send_frame(9'h0A5, 1'b0, 1'b0, 1'b0, 3, 1);
            idle(spb());
            wait_valid();
            expect_head(9'h0A5, 1'b0, 1'b0, "R3");
            pop();
            send_frame(9'h0A5, 1'b0, 1'b0, 1'b0, 3, 2);
            idle(spb());
            wait_valid();
            expect_head(9'h0AD, 1'b0, 1'b0, "R3");
            pop();
        end

        // R4: start glitches
        dbl_speed = 1'b0;
        idle(4);
        slot(1'b0);
        idle(40);
        chk(rd_valid == 1'b0, "R4", "one-sample glitch", rd_valid, 0);
        for (int j = 0; j < 7; j++) slot(1'b0);
        idle(40);
        chk(rd_valid == 1'b0, "R4", "seven-sample glitch", rd_valid, 0);

        // R2: low level while no tick is issued
        @(negedge clk);
        tick_gate = 1'b0;
        rx_in = 1'b0;
        repeat (200) @(negedge clk);
        rx_in = 1'b1;
        repeat (8) @(negedge clk);
        tick_gate = 1'b1;
        idle(40);
        chk(rd_valid == 1'b0, "R2", "no tick no frame", rd_valid, 0);

        // R5: length clamping
        word_len = 4'd3;
        idle(4);
        frame_and_check(9'h1F3, 1'b0, 1'b0, "R5");
        word_len = 4'd15;
        idle(4);
        frame_and_check(9'h1C6, 1'b0, 1'b0, "R5");

        // R6 / R7 directed: odd parity error, frame error with even parity
        word_len = 4'd7;
        parity_sel = 2'b11;
        idle(4);
        frame_and_check(9'h05A, 1'b1, 1'b0, "R6");
        parity_sel = 2'b10;
        idle(4);
        frame_and_check(9'h033, 1'b0, 1'b1, "R7");

        // R8: next start right after the shortened stop bit, both speeds
        parity_sel = 2'b00;
        word_len = 4'd8;
        for (int m = 0; m < 2; m++) begin
            dbl_speed = 1'(m);
            idle(4);
            send_frame(9'h0C3, 1'b0, 1'b0, 1'b1, -1, 0);
            send_frame(9'h03C, 1'b0, 1'b0, 1'b0, -1, 0);
            idle(spb());
            wait_valid();
            expect_head(9'h0C3, 1'b0, 1'b0, "R8");
            pop();
            expect_head(9'h03C, 1'b0, 1'b0, "R8");
            pop();
            chk(rd_valid == 1'b0, "R9", "empty after pair", rd_valid, 0);
        end

        // R9 / R10: fill, overflow, drain in order
        dbl_speed = 1'b1;
        a = 9'h011; b2 = 9'h022; c = 9'h044;
        idle(4);
        send_frame(a, 1'b0, 1'b0, 1'b0, -1, 0);
        idle(4);
        send_frame(b2, 1'b0, 1'b0, 1'b0, -1, 0);
        idle(4);
        send_frame(c, 1'b0, 1'b0, 1'b0, -1, 0);
        idle(spb());
        chk(overrun == 1'b1, "R10", "overrun set", overrun, 1);
        expect_head(a, 1'b0, 1'b0, "R9");
        pop();
        chk(overrun == 1'b0, "R10", "overrun cleared by read", overrun, 0);
        expect_head(b2, 1'b0, 1'b0, "R9");
        pop();
        chk(rd_valid == 1'b0, "R10", "third word dropped", rd_valid, 0);

        // R11: flush on disable, frames ignored while disabled
        idle(4);
        send_frame(a, 1'b0, 1'b0, 1'b0, -1, 0);
        idle(4);
        send_frame(b2, 1'b0, 1'b0, 1'b0, -1, 0);
        idle(spb());
        chk(rd_valid == 1'b1, "R9", "words queued", rd_valid, 1);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R11", "flushed", rd_valid, 0);
        idle(4);
        send_frame(c, 1'b0, 1'b0, 1'b0, -1, 0);
        idle(spb());
        chk(rd_valid == 1'b0, "R11", "ignored while disabled", rd_valid, 0);
        rx_en = 1'b1;
        idle(4);
        frame_and_check(9'h0F0, 1'b0, 1'b0, "R11");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule